// File: doc/BRIEF.md
# Serial power-management control register bank

This block turns 8-bit control words, shifted in over a three-wire serial link, into the enable, mode and level signals of a small power-management controller. A host lowers the active-low select line and clocks in one word, most significant bit first. The word opens with a 3-bit address and ends with a 5-bit data field. When the first address bit is 1, the seven bits that follow it are a comparator DAC code and not a register write. The word is committed when select rises, and only if exactly eight serial clocks came in while it was low.

While the word is shifting in, the block shifts a status byte out on the serial output. It captures that byte when select falls. The byte carries three comparator results and a low-battery flag. The comparators are evaluated against the DAC code written by the previous frame, so each result arrives one transaction late. Several outputs combine a register bit with a pin. Run mode is the run bit ORed with an external run pin. The second driver gate is its enable bit ANDed with an external audio-rate clock. Two resets return every register to its default value: the power-on reset and an external reset-detector input.

All serial inputs are oversampled by the system clock through synchronisers. The serial clock must therefore stay high and low for at least three system clocks each. The link has no back-pressure: the host owns the pace and the block never stalls it.

Top module: `pmc_ctrl_bank`

## Requirements
- R1: A frame is committed on the rising edge of `csn` only when exactly 8 rising edges of `sclk` occurred while `csn` was low. Bits are taken MSB first: frame bit 7 is address bit 2, bits 6:5 are address bits 1:0, and bits 4:0 are data D4..D0.
- R2: A frame with any other count of `sclk` rising edges (for example 0, 7 or 9) changes no register.
- R3: Address 000 loads the following fields: D4 drives `drv2_en` gating, D3 `drv1_on`, D2 the run bit, D1 `ldo_a_en` and D0 `ldo_b_en`.
- R4: Address 001 loads the following fields: D3 `lb_backup_en`, D2 the slow (1 mA) charge enable, D1 the fast (15 mA) charge enable and D0 `backup_en`. D4 of this address is ignored.
- R5: Address 010 loads the 5-bit `vout_code` from D4..D0. A write to address 011 changes no output.
- R6: When frame bit 7 is 1, frame bits 6:0 load `dac_code`, with frame bit 0 as its LSB, and no other register changes.
- R7: `cmp_en` is high exactly when `dac_code` is nonzero.
- R8: After power-on reset, and after any cycle with `det_n` low, every register holds its default. All defaults are 0 except `vout_code`, which is 5'b01001. A frame committed while `det_n` is low is ignored.
- R9: `run_mode` is the run bit ORed with `run_pin`. It is low only when both are low.
- R10: `drv2_on` is the address-000 D4 bit ANDed with `tone_in`. `drv1_on` follows its bit alone.
- R11: `chg_on` is high when either charge enable is set. `chg_fast` is high whenever the fast enable is set, so the fast current wins when both enables are set.
- R12: During a frame, `sdo` presents MSB first the byte {`cmp_res[2]`, `cmp_res[1]`, `cmp_res[0]`, `lowbat`, 4'b0000}, captured when `csn` falls. It advances one bit after each `sclk` rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| det_n | input | 1 | External reset-detector input; low forces register defaults |
| sclk | input | 1 | Serial clock from host |
| csn | input | 1 | Serial select, active low |
| sdi | input | 1 | Serial data in, MSB first |
| sdo | output | 1 | Serial status data out, MSB first |
| run_pin | input | 1 | External run request |
| tone_in | input | 1 | External audio-rate clock for the second driver |
| cmp_res | input | 3 | Comparator results from the analog channels |
| lowbat | input | 1 | Low-battery detector status |
| run_mode | output | 1 | Effective run mode (high) or coast mode (low) |
| drv1_on | output | 1 | First open-drain driver gate |
| drv2_on | output | 1 | Second open-drain driver gate |
| ldo_a_en | output | 1 | Enable of the first low-noise regulator |
| ldo_b_en | output | 1 | Enable of the second low-noise regulator |
| chg_on | output | 1 | Charger current source enable |
| chg_fast | output | 1 | Charger current select: 1 = 15 mA, 0 = 1 mA |
| backup_en | output | 1 | Backup regulator enable |
| lb_backup_en | output | 1 | Allows the low-battery detector to engage backup |
| vout_code | output | 5 | Output-voltage code |
| dac_code | output | 7 | Comparator DAC code |
| cmp_en | output | 1 | Enable of the DAC and channel comparators |

## Verification
The hardest cases to reach are the frames that must be thrown away, and resets that land while a write is pending. A normal host never sends 7 or 9 clocks, and it never holds the reset detector low across a commit. The stimulus reaches these cases in two ways. Directed frames with 0, 7 and 9 serial clocks are sent, as is a full frame while `det_n` is held low. The random phase also gives about one frame in five a wrong clock count, with random data on the ninth bit. Run pin, tone input and comparator inputs are varied on every frame, so the gated outputs and the captured status byte are each checked in both states.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned DATA_W  = 5;
  localparam int unsigned FRAME_W = ADDR_W + DATA_W;
  localparam int unsigned DAC_W   = FRAME_W - 1;
  localparam int unsigned VOUT_W  = DATA_W;
  localparam int unsigned CMP_N   = 3;
  localparam logic [VOUT_W-1:0] VOUT_DEFAULT = 5'b01001;

  typedef struct packed {
    logic drv2;
    logic drv1;
    logic run;
    logic ldo_a;
    logic ldo_b;
  } main_ctl_t;

  typedef struct packed {
    logic lb_backup;
    logic chg_slow;
    logic chg_fast;
    logic backup;
  } aux_ctl_t;

  typedef enum logic [1:0] {
    SEL_MAIN = 2'b00,
    SEL_AUX  = 2'b01,
    SEL_VOUT = 2'b10,
    SEL_NONE = 2'b11
  } reg_sel_e;
endpackage

// File: rtl/pmc_serial_rx.sv
module pmc_serial_rx #(
  parameter int unsigned FRAME_W     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_i,
  input  logic               csn_i,
  input  logic               sdi_i,
  input  logic [FRAME_W-1:0] rd_byte_i,
  output logic               sdo_o,
  output logic               commit_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(FRAME_W);

  // synchroniser chain, bit order {sclk, csn, sdi}
  logic [2:0] sync_q [SYNC_STAGES];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= 3'b010;
    end else begin
      sync_q[0] <= {sclk_i, csn_i, sdi_i};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  logic sclk_s, csn_s, sdi_s;
  assign {sclk_s, csn_s, sdi_s} = sync_q[SYNC_STAGES-1];

  logic sclk_q, csn_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      csn_q  <= csn_s;
    end
  end

  logic sclk_rise, cs_fall, cs_rise;
  assign sclk_rise = sclk_s & ~sclk_q;
  assign cs_fall   = ~csn_s & csn_q;
  assign cs_rise   = csn_s & ~csn_q;

  logic               active_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] shin_q;
  logic [FRAME_W-1:0] shout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      shin_q   <= '0;
      shout_q  <= '0;
      commit_o <= 1'b0;
      frame_o  <= '0;
    end else begin
      commit_o <= 1'b0;
      if (cs_fall) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        shin_q   <= '0;
        shout_q  <= rd_byte_i;
      end else if (cs_rise) begin
        active_q <= 1'b0;
        if (active_q) begin
          commit_o <= (cnt_q == CNT_GOOD);
          frame_o  <= shin_q;
        end
      end else if (active_q && !csn_s && sclk_rise) begin
        shin_q  <= {shin_q[FRAME_W-2:0], sdi_s};
        shout_q <= {shout_q[FRAME_W-2:0], 1'b0};
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sdo_o = shout_q[FRAME_W-1];

  // R1: a commit is a single-cycle pulse issued only once select is high
  a_r1_commit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o);
  a_r1_commit_select_high: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> csn_s);
  // R2: the bit counter never wraps back to a valid count
  a_r2_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !cs_fall) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/pmc_regfile.sv
module pmc_regfile
  import pmc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               det_n_i,
  input  logic               commit_i,
  input  logic [FRAME_W-1:0] frame_i,
  output main_ctl_t          main_o,
  output aux_ctl_t           aux_o,
  output logic [VOUT_W-1:0]  vout_o,
  output logic [DAC_W-1:0]   dac_o
);
  logic              is_dac;
  reg_sel_e          sel;
  logic [DATA_W-1:0] data;

  assign is_dac = frame_i[FRAME_W-1];
  assign sel    = reg_sel_e'(frame_i[FRAME_W-2 -: 2]);
  assign data   = frame_i[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_o <= '0;
      aux_o  <= '0;
      vout_o <= VOUT_DEFAULT;
      dac_o  <= '0;
    end else if (!det_n_i) begin
      main_o <= '0;
      aux_o  <= '0;
      vout_o <= VOUT_DEFAULT;
      dac_o  <= '0;
    end else if (commit_i) begin
      if (is_dac) begin
        dac_o <= frame_i[DAC_W-1:0];
      end else begin
        case (sel)
          SEL_MAIN: main_o <= main_ctl_t'(data);
          SEL_AUX:  aux_o  <= aux_ctl_t'(data[DATA_W-2:0]);
          SEL_VOUT: vout_o <= data;
          default:  ;
        endcase
      end
    end
  end

  // R8: a cycle with the detector low leaves every register at default
  a_r8_det_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    !det_n_i |=> (main_o == '0 && aux_o == '0 && vout_o == VOUT_DEFAULT && dac_o == '0));
  // R5: address 011 leaves every register untouched
  a_r5_addr3_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && det_n_i && !frame_i[FRAME_W-1] && frame_i[FRAME_W-2 -: 2] == 2'b11)
      |=> $stable({main_o, aux_o, vout_o, dac_o}));
  // R6: a DAC frame loads the code and touches nothing else
  a_r6_dac_load: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && det_n_i && frame_i[FRAME_W-1])
      |=> (dac_o == $past(frame_i[DAC_W-1:0]) && $stable({main_o, aux_o, vout_o})));
  // R2: registers only change on a commit or a detector reset
  a_r2_no_change_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_i && det_n_i) |=> $stable({main_o, aux_o, vout_o, dac_o}));
endmodule

// File: rtl/pmc_outmap.sv
module pmc_outmap
  import pmc_pkg::*;
(
  input  main_ctl_t          main_i,
  input  aux_ctl_t           aux_i,
  input  logic [DAC_W-1:0]   dac_i,
  input  logic               run_pin_i,
  input  logic               tone_i,
  input  logic [CMP_N-1:0]   cmp_i,
  input  logic               lowbat_i,
  output logic               run_mode_o,
  output logic               drv1_o,
  output logic               drv2_o,
  output logic               chg_on_o,
  output logic               chg_fast_o,
  output logic               cmp_en_o,
  output logic [FRAME_W-1:0] rd_byte_o
);
  localparam int unsigned PAD_W = FRAME_W - CMP_N - 1;

  assign run_mode_o = main_i.run | run_pin_i;
  assign drv1_o     = main_i.drv1;
  assign drv2_o     = main_i.drv2 & tone_i;
  assign chg_on_o   = aux_i.chg_fast | aux_i.chg_slow;
  assign chg_fast_o = aux_i.chg_fast;
  assign cmp_en_o   = |dac_i;
  assign rd_byte_o  = {cmp_i, lowbat_i, {PAD_W{1'b0}}};
endmodule

// File: rtl/pmc_ctrl_bank.sv
module pmc_ctrl_bank
  import pmc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               det_n,
  input  logic               sclk,
  input  logic               csn,
  input  logic               sdi,
  output logic               sdo,
  input  logic               run_pin,
  input  logic               tone_in,
  input  logic [CMP_N-1:0]   cmp_res,
  input  logic               lowbat,
  output logic               run_mode,
  output logic               drv1_on,
  output logic               drv2_on,
  output logic               ldo_a_en,
  output logic               ldo_b_en,
  output logic               chg_on,
  output logic               chg_fast,
  output logic               backup_en,
  output logic               lb_backup_en,
  output logic [VOUT_W-1:0]  vout_code,
  output logic [DAC_W-1:0]   dac_code,
  output logic               cmp_en
);
  logic               commit;
  logic [FRAME_W-1:0] frame;
  logic [FRAME_W-1:0] rd_byte;
  main_ctl_t          main_q;
  aux_ctl_t           aux_q;

  pmc_serial_rx #(.FRAME_W(FRAME_W), .SYNC_STAGES(SYNC_STAGES)) i_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_i    (sclk),
    .csn_i     (csn),
    .sdi_i     (sdi),
    .rd_byte_i (rd_byte),
    .sdo_o     (sdo),
    .commit_o  (commit),
    .frame_o   (frame)
  );

  pmc_regfile i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .det_n_i  (det_n),
    .commit_i (commit),
    .frame_i  (frame),
    .main_o   (main_q),
    .aux_o    (aux_q),
    .vout_o   (vout_code),
    .dac_o    (dac_code)
  );

  pmc_outmap i_map (
    .main_i     (main_q),
    .aux_i      (aux_q),
    .dac_i      (dac_code),
    .run_pin_i  (run_pin),
    .tone_i     (tone_in),
    .cmp_i      (cmp_res),
    .lowbat_i   (lowbat),
    .run_mode_o (run_mode),
    .drv1_o     (drv1_on),
    .drv2_o     (drv2_on),
    .chg_on_o   (chg_on),
    .chg_fast_o (chg_fast),
    .cmp_en_o   (cmp_en),
    .rd_byte_o  (rd_byte)
  );

  assign ldo_a_en     = main_q.ldo_a;
  assign ldo_b_en     = main_q.ldo_b;
  assign backup_en    = aux_q.backup;
  assign lb_backup_en = aux_q.lb_backup;

  // R9: the pin alone forces run mode
  a_r9_pin_forces_run: assert property (@(posedge clk) disable iff (!rst_n)
    run_pin |-> run_mode);
  // R10: without the tone clock the second driver stays off
  a_r10_tone_gates_drv2: assert property (@(posedge clk) disable iff (!rst_n)
    !tone_in |-> !drv2_on);
  // R11: selecting fast charge implies the charger is on
  a_r11_fast_implies_on: assert property (@(posedge clk) disable iff (!rst_n)
    chg_fast |-> chg_on);
  // R7: comparator enable tracks a nonzero DAC code
  a_r7_cmp_en_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code == '0) |-> !cmp_en);
endmodule

// File: tb/test_pmc_ctrl_bank.sv
module test_pmc_ctrl_bank;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, det_n, sclk, csn, sdi, sdo, run_pin, tone_in, lowbat;
  logic [2:0] cmp_res;
  logic       run_mode, drv1_on, drv2_on, ldo_a_en, ldo_b_en, chg_on, chg_fast;
  logic       backup_en, lb_backup_en, cmp_en;
  logic [4:0] vout_code;
  logic [6:0] dac_code;

  pmc_ctrl_bank i_pmc_ctrl_bank (
    .clk(clk), .rst_n(rst_n), .det_n(det_n), .sclk(sclk), .csn(csn), .sdi(sdi),
    .sdo(sdo), .run_pin(run_pin), .tone_in(tone_in), .cmp_res(cmp_res),
    .lowbat(lowbat), .run_mode(run_mode), .drv1_on(drv1_on), .drv2_on(drv2_on),
    .ldo_a_en(ldo_a_en), .ldo_b_en(ldo_b_en), .chg_on(chg_on), .chg_fast(chg_fast),
    .backup_en(backup_en), .lb_backup_en(lb_backup_en), .vout_code(vout_code),
    .dac_code(dac_code), .cmp_en(cmp_en)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [4:0] m_main;
  logic [3:0] m_aux;
  logic [4:0] m_vout;
  logic [6:0] m_dac;

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_main = '0; m_aux = '0; m_vout = 5'b01001; m_dac = '0;
  endtask

  task automatic model_write(input logic [7:0] b);
    if (b[7]) m_dac = b[6:0];
    else case (b[6:5])
      2'b00: m_main = b[4:0];
      2'b01: m_aux  = b[3:0];
      2'b10: m_vout = b[4:0];
      default: ;
    endcase
  endtask

  function automatic logic [7:0] exp_rd(input logic [2:0] c, input logic lb);
    return {c, lb, 4'b0000};
  endfunction

  task automatic check_outputs(input string tag);
    chk("R10", {tag, " drv1_on"}, drv1_on, m_main[3]);
    chk("R10", {tag, " drv2_on"}, drv2_on, m_main[4] & tone_in);
    chk("R9",  {tag, " run_mode"}, run_mode, m_main[2] | run_pin);
    chk("R3",  {tag, " ldo_a_en"}, ldo_a_en, m_main[1]);
    chk("R3",  {tag, " ldo_b_en"}, ldo_b_en, m_main[0]);
    chk("R4",  {tag, " lb_backup_en"}, lb_backup_en, m_aux[3]);
    chk("R4",  {tag, " backup_en"}, backup_en, m_aux[0]);
    chk("R11", {tag, " chg_on"}, chg_on, m_aux[2] | m_aux[1]);
    chk("R11", {tag, " chg_fast"}, chg_fast, m_aux[1]);
    chk("R5",  {tag, " vout_code"}, vout_code, m_vout);
    chk("R6",  {tag, " dac_code"}, dac_code, m_dac);
    chk("R7",  {tag, " cmp_en"}, cmp_en, m_dac != 0);
  endtask

  task automatic send(input logic [7:0] b, input int nclk, output logic [7:0] got);
    got = '0;
    csn = 1'b0;
    repeat (5) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 8) ? b[7-i] : 1'($urandom);
      repeat (2) @(negedge clk);
      if (i < 8) got[7-i] = sdo;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (2) @(negedge clk);
    end
    csn = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] b, input int nclk, input string tag);
    logic [7:0] got;
    logic [7:0] exp;
    exp = exp_rd(cmp_res, lowbat);
    send(b, nclk, got);
    if (nclk >= 8) chk("R12", {tag, " sdo byte"}, got, exp);
    if (nclk == 8 && det_n) model_write(b);
    check_outputs(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; det_n = 1'b1; sclk = 1'b0; csn = 1'b1; sdi = 1'b0;
    run_pin = 1'b0; tone_in = 1'b1; cmp_res = 3'b000; lowbat = 1'b0;
    model_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_outputs("R8 power-on");

    // R3 all main bits, R12 status byte pattern
    cmp_res = 3'b101; lowbat = 1'b1;
    frame(8'b000_11111, 8, "R3 main all");
    tone_in = 1'b0; @(negedge clk);
    check_outputs("R10 tone low");
    run_pin = 1'b1; @(negedge clk);
    frame(8'b000_00000, 8, "R9 pin only");
    run_pin = 1'b0; @(negedge clk);
    check_outputs("R9 coast");
    // R4 D4 ignored, R11 both charge bits
    cmp_res = 3'b010; lowbat = 1'b0;
    frame(8'b001_11111, 8, "R4 aux all");
    frame(8'b001_00100, 8, "R11 slow only");
    frame(8'b010_10110, 8, "R5 vout");
    frame(8'b011_11111, 8, "R5 addr3 ignored");
    frame(8'b111_11111, 8, "R6 dac max");
    frame(8'b100_00001, 8, "R6 dac one");
    frame(8'b100_00000, 8, "R7 dac zero");
    // R2 wrong counts
    frame(8'b010_00000, 7, "R2 seven clocks");
    frame(8'b010_00000, 9, "R2 nine clocks");
    frame(8'b010_00000, 0, "R2 zero clocks");
    frame(8'b010_00011, 8, "R1 good after bad");
    // R8 detector pulse and write during detector low
    frame(8'b000_10101, 8, "R1 main");
    det_n = 1'b0; repeat (2) @(negedge clk);
    det_n = 1'b1; @(negedge clk);
    model_reset();
    check_outputs("R8 detector pulse");
    det_n = 1'b0;
    frame(8'b001_01111, 8, "R8 write under detector");
    det_n = 1'b1; @(negedge clk);
    check_outputs("R8 detector release");

    for (int k = 0; k < 80; k++) begin
      logic [7:0] b;
      int nc;
      b = 8'($urandom);
      nc = (($urandom % 5) == 0) ? ((($urandom % 2) == 0) ? 7 : 9) : 8;
      run_pin = 1'($urandom); tone_in = 1'($urandom);
      cmp_res = 3'($urandom); lowbat = 1'($urandom);
      @(negedge clk);
      frame(b, nc, "R1 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule